// File: doc/BRIEF.md
# Wishbone Memory-Window Request Decoder

This block is the host-facing front end of a bridge that lets a processor use a serial memory as if it were ordinary memory. It receives single Wishbone b4 transfers in either classic or pipelined form. A transfer is claimed when its address lies inside a window whose size is a power of two and whose base is aligned to that size. The byte-select mask is then turned into an access size and a starting byte lane. The claimed transfer becomes one request to a downstream memory sequencer.

When the sequencer reports completion, the host sees a single acknowledge pulse, and a read returns the full 32-bit word. A mask the block does not support never reaches the sequencer. Instead the host sees a single error pulse. Data is little-endian: the selected low byte of a write leaves on bits 7:0 of the request data. The block has an asynchronous low-active reset, and also a synchronous low-active reset that application logic can drive.

Top module: `wbw_front`

## Requirements
- R1: During and directly after either reset, `wb_ack_o`, `wb_err_o` and `mreq_valid_o` are low, and the block is idle, ready to accept a transfer.
- R2: In classic mode, with `wb_cyc_i` and `wb_stb_i` held high, a legal transfer issues exactly one request. Exactly one `wb_ack_o` pulse follows in the cycle after the edge that samples `mrsp_done_i` high.
- R3: In pipelined mode, `wb_stb_i` is high for only the first cycle, and the transfer is captured on that cycle. Its completion behaves as in R2.
- R4: A read is legal only with mask 1111, and its size is word. On the ack cycle, `wb_dat_o` carries the `mrsp_rdata_i` value sampled at the completion edge.
- R5: Legal write masks, with size code (00 byte, 01 half, 10 word) and lane: 1111 gives word, lane 0. 0011 gives half, lane 0. 1100 gives half, lane 2. 0001, 0010, 0100 and 1000 give byte, lanes 0 to 3 respectively. `mreq_offs_o` is the address minus the window base, with bits 1:0 replaced by the lane. Word accesses use lane 0.
- R6: Any other mask, or a read with a mask other than 1111, gives a single `wb_err_o` pulse one cycle after capture, and no request is issued.
- R7: A transfer is ignored, with no request, no ack and no err, when its address lies outside [base, base+size) or when `wb_cyc_i` or `wb_stb_i` is low.
- R8: `wb_ack_o` and `wb_err_o` are never high together, and each lasts exactly one cycle.
- R9: While a transfer is in flight, further strobes are ignored until its ack or err pulse has been issued. `mreq_valid_o` lasts exactly one cycle.
- R10: A synchronous reset taken mid-transfer abandons the transfer. A later `mrsp_done_i` then produces no ack.
- R11: `mreq_wdata_o` is `wb_dat_i` shifted right by eight times the lane, so the first selected byte sits on bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_an_i | input | 1 | Asynchronous reset, low-active |
| rst_sn_i | input | 1 | Synchronous reset, low-active |
| wb_adr_i | input | 32 | Byte address |
| wb_dat_i | input | 32 | Write data from host |
| wb_dat_o | output | 32 | Read data to host |
| wb_we_i | input | 1 | High for write |
| wb_sel_i | input | 4 | Byte-select mask |
| wb_stb_i | input | 1 | Strobe |
| wb_cyc_i | input | 1 | Cycle valid |
| wb_ack_o | output | 1 | Successful termination pulse |
| wb_err_o | output | 1 | Error termination pulse |
| mreq_valid_o | output | 1 | One-cycle request to sequencer |
| mreq_write_o | output | 1 | Request is a write |
| mreq_size_o | output | 2 | Size code: 00 byte, 01 half, 10 word |
| mreq_offs_o | output | OFFS_W | Byte offset inside the window |
| mreq_wdata_o | output | 32 | Write data aligned to bit 0 |
| mrsp_done_i | input | 1 | Sequencer completion pulse |
| mrsp_rdata_i | input | 32 | Read word from sequencer |

## Verification
The bench builds the block with a 4 KB window based at 0x4000_3000. Addresses one word below the base and exactly at base plus size therefore sit right next to the window's edges, and the 12-bit offset can be checked in full. The behavioural sequencer model has a latency the bench can set. Setting it long enough keeps a transfer in flight while a second strobe arrives, and also while a synchronous reset cuts the transfer short.

// File: rtl/wbw_pkg.sv
package wbw_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_WAIT = 2'b01,
        ST_DONE = 2'b10
    } xfer_state_e;

    typedef struct packed {
        logic       ok;
        size_e      size;
        logic [1:0] lane;
    } sel_info_t;

    // Classify a byte-select mask for the given direction.
    function automatic sel_info_t classify_sel(input logic is_wr, input logic [3:0] sel);
        sel_info_t r;
        r = '{ok: 1'b0, size: SZ_BYTE, lane: 2'd0};
        if (sel == 4'b1111) begin
            r = '{ok: 1'b1, size: SZ_WORD, lane: 2'd0};
        end else if (is_wr) begin
            unique case (sel)
                4'b0011: r = '{ok: 1'b1, size: SZ_HALF, lane: 2'd0};
                4'b1100: r = '{ok: 1'b1, size: SZ_HALF, lane: 2'd2};
                4'b0001: r = '{ok: 1'b1, size: SZ_BYTE, lane: 2'd0};
                4'b0010: r = '{ok: 1'b1, size: SZ_BYTE, lane: 2'd1};
                4'b0100: r = '{ok: 1'b1, size: SZ_BYTE, lane: 2'd2};
                4'b1000: r = '{ok: 1'b1, size: SZ_BYTE, lane: 2'd3};
                default: r = '{ok: 1'b0, size: SZ_BYTE, lane: 2'd0};
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/wbw_window_match.sv
module wbw_window_match #(
    parameter logic [31:0] WIN_BASE  = 32'hF000_0000,
    parameter int          WIN_BYTES = 65536
) (
    input  logic [31:0] adr_i,
    output logic        hit_o
);
    localparam logic [31:0] SIZE_M1 = 32'(WIN_BYTES) - 32'd1;
    localparam logic [31:0] HI_MASK = ~SIZE_M1;

    always_comb begin
        hit_o = (((adr_i ^ WIN_BASE) & HI_MASK) == 32'd0);
    end
endmodule

// File: rtl/wbw_sel_decode.sv
module wbw_sel_decode
    import wbw_pkg::*;
(
    input  logic       we_i,
    input  logic [3:0] sel_i,
    output sel_info_t  info_o
);
    always_comb begin
        info_o = classify_sel(we_i, sel_i);
    end
endmodule

// File: rtl/wbw_xfer_ctrl.sv
module wbw_xfer_ctrl
    import wbw_pkg::*;
#(
    parameter int OFFS_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_an_i,
    input  logic              rst_sn_i,
    input  logic              claim_i,
    input  sel_info_t         info_i,
    input  logic [OFFS_W-1:0] offs_i,
    input  logic              we_i,
    input  logic [31:0]       dat_i,
    input  logic              done_i,
    input  logic [31:0]       rdata_i,
    output logic              ack_o,
    output logic              err_o,
    output logic [31:0]       dat_o,
    output logic              req_valid_o,
    output logic              req_write_o,
    output size_e             req_size_o,
    output logic [OFFS_W-1:0] req_offs_o,
    output logic [31:0]       req_wdata_o
);
    xfer_state_e state_q;
    logic [4:0]  shamt;

    always_comb begin
        shamt = {info_i.lane, 3'b000};
    end

    always_ff @(posedge clk_i or negedge rst_an_i) begin
        if (!rst_an_i) begin
            state_q     <= ST_IDLE;
            ack_o       <= 1'b0;
            err_o       <= 1'b0;
            dat_o       <= '0;
            req_valid_o <= 1'b0;
            req_write_o <= 1'b0;
            req_size_o  <= SZ_BYTE;
            req_offs_o  <= '0;
            req_wdata_o <= '0;
        end else if (!rst_sn_i) begin
            state_q     <= ST_IDLE;
            ack_o       <= 1'b0;
            err_o       <= 1'b0;
            dat_o       <= '0;
            req_valid_o <= 1'b0;
            req_write_o <= 1'b0;
            req_size_o  <= SZ_BYTE;
            req_offs_o  <= '0;
            req_wdata_o <= '0;
        end else begin
            req_valid_o <= 1'b0;
            ack_o       <= 1'b0;
            err_o       <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (claim_i) begin
                        if (info_i.ok) begin
                            req_valid_o <= 1'b1;
                            req_write_o <= we_i;
                            req_size_o  <= info_i.size;
                            req_offs_o  <= {offs_i[OFFS_W-1:2], info_i.lane};
                            req_wdata_o <= dat_i >> shamt;
                            state_q     <= ST_WAIT;
                        end else begin
                            err_o   <= 1'b1;
                            state_q <= ST_DONE;
                        end
                    end
                end
                ST_WAIT: begin
                    if (done_i) begin
                        ack_o   <= 1'b1;
                        dat_o   <= rdata_i;
                        state_q <= ST_DONE;
                    end
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R8
    ack_err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_an_i || !rst_sn_i)
        !(ack_o && err_o));

    // R8
    term_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_an_i || !rst_sn_i)
        (ack_o || err_o) |=> !(ack_o || err_o));

    // R9
    req_single_chk: assert property (@(posedge clk_i) disable iff (!rst_an_i || !rst_sn_i)
        req_valid_o |=> !req_valid_o);

    // R2
    ack_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_an_i || !rst_sn_i)
        ack_o |-> $past(done_i));

    // R4
    rdata_return_chk: assert property (@(posedge clk_i) disable iff (!rst_an_i || !rst_sn_i)
        ack_o |-> (dat_o == $past(rdata_i)));
endmodule

// File: rtl/wbw_front.sv
module wbw_front
    import wbw_pkg::*;
#(
    parameter logic [31:0] WIN_BASE  = 32'hF000_0000,
    parameter int          WIN_BYTES = 65536,
    parameter int          OFFS_W    = $clog2(WIN_BYTES)
) (
    input  logic              clk_i,
    input  logic              rst_an_i,
    input  logic              rst_sn_i,
    input  logic [31:0]       wb_adr_i,
    input  logic [31:0]       wb_dat_i,
    output logic [31:0]       wb_dat_o,
    input  logic              wb_we_i,
    input  logic [3:0]        wb_sel_i,
    input  logic              wb_stb_i,
    input  logic              wb_cyc_i,
    output logic              wb_ack_o,
    output logic              wb_err_o,
    output logic              mreq_valid_o,
    output logic              mreq_write_o,
    output logic [1:0]        mreq_size_o,
    output logic [OFFS_W-1:0] mreq_offs_o,
    output logic [31:0]       mreq_wdata_o,
    input  logic              mrsp_done_i,
    input  logic [31:0]       mrsp_rdata_i
);
    logic      win_hit;
    logic      claim;
    sel_info_t info;
    size_e     size_q;

    wbw_window_match #(
        .WIN_BASE (WIN_BASE),
        .WIN_BYTES(WIN_BYTES)
    ) i_match (
        .adr_i(wb_adr_i),
        .hit_o(win_hit)
    );

    wbw_sel_decode i_dec (
        .we_i  (wb_we_i),
        .sel_i (wb_sel_i),
        .info_o(info)
    );

    always_comb begin
        claim = wb_cyc_i && wb_stb_i && win_hit;
    end

    wbw_xfer_ctrl #(
        .OFFS_W(OFFS_W)
    ) i_ctrl (
        .clk_i      (clk_i),
        .rst_an_i   (rst_an_i),
        .rst_sn_i   (rst_sn_i),
        .claim_i    (claim),
        .info_i     (info),
        .offs_i     (wb_adr_i[OFFS_W-1:0]),
        .we_i       (wb_we_i),
        .dat_i      (wb_dat_i),
        .done_i     (mrsp_done_i),
        .rdata_i    (mrsp_rdata_i),
        .ack_o      (wb_ack_o),
        .err_o      (wb_err_o),
        .dat_o      (wb_dat_o),
        .req_valid_o(mreq_valid_o),
        .req_write_o(mreq_write_o),
        .req_size_o (size_q),
        .req_offs_o (mreq_offs_o),
        .req_wdata_o(mreq_wdata_o)
    );

    always_comb begin
        mreq_size_o = size_q;
    end

    // R7
    req_in_window_chk: assert property (@(posedge clk_i) disable iff (!rst_an_i || !rst_sn_i)
        mreq_valid_o |-> $past(win_hit && wb_cyc_i && wb_stb_i));

    // R6
    err_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_an_i || !rst_sn_i)
        wb_err_o |-> (!mreq_valid_o && !$past(mreq_valid_o)));
endmodule

// File: tb/test_wbw_front.sv
module test_wbw_front;
    localparam logic [31:0] BASE = 32'h4000_3000;
    localparam int          SIZE = 4096;
    localparam int          OW   = 12;

    logic          clk = 1'b0;
    logic          rst_an = 1'b0;
    logic          rst_sn = 1'b1;
    logic [31:0]   adr = '0, wdat = '0;
    logic [31:0]   rdat;
    logic          we = 1'b0, stb = 1'b0, cyc = 1'b0;
    logic [3:0]    sel = '0;
    logic          ack, err, rq_v, rq_w;
    logic [1:0]    rq_sz;
    logic [OW-1:0] rq_off;
    logic [31:0]   rq_wd;
    logic          sq_done = 1'b0;
    logic [31:0]   sq_rdata = '0;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    int sq_lat  = 2;

    always #4 clk = ~clk;

    wbw_front #(.WIN_BASE(BASE), .WIN_BYTES(SIZE)) i_wbw_front (
        .clk_i(clk), .rst_an_i(rst_an), .rst_sn_i(rst_sn),
        .wb_adr_i(adr), .wb_dat_i(wdat), .wb_dat_o(rdat), .wb_we_i(we),
        .wb_sel_i(sel), .wb_stb_i(stb), .wb_cyc_i(cyc),
        .wb_ack_o(ack), .wb_err_o(err),
        .mreq_valid_o(rq_v), .mreq_write_o(rq_w), .mreq_size_o(rq_sz),
        .mreq_offs_o(rq_off), .mreq_wdata_o(rq_wd),
        .mrsp_done_i(sq_done), .mrsp_rdata_i(sq_rdata)
    );

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Behavioural sequencer: answers each request after sq_lat cycles.
    int          sq_cnt = 0;
    bit          sq_busy = 0;
    logic [31:0] sq_off = '0;
    always @(posedge clk) begin
        sq_done <= 1'b0;
        if (rq_v) begin
            sq_busy = 1;
            sq_cnt  = sq_lat;
            sq_off  = 32'(rq_off);
        end else if (sq_busy) begin
            if (sq_cnt == 0) begin
                sq_done  <= 1'b1;
                sq_rdata <= 32'hC0DE_0000 ^ (sq_off * 32'h0001_0011);
                sq_busy  = 0;
            end else begin
                sq_cnt--;
            end
        end
    end

    // Specification of legal masks, written from the requirement table.
    function automatic void spec(input logic w, input logic [3:0] s,
                                 output bit ok, output logic [1:0] sz, output logic [1:0] ln);
        int n;
        n  = $countones(s);
        ln = 2'd0;
        for (int i = 3; i >= 0; i--) if (s[i]) ln = 2'(i);
        ok = 0;
        sz = 2'b00;
        if (s == 4'hF) begin ok = 1; sz = 2'b10; ln = 2'd0; end
        else if (w && n == 1) begin ok = 1; sz = 2'b00; end
        else if (w && (s == 4'h3 || s == 4'hC)) begin ok = 1; sz = 2'b01; end
    endfunction

    // Cycle reference model
    int            m_phase = 0;
    bit            m_ack = 0, m_err = 0, m_req = 0, m_wr = 0, m_last_wr = 0;
    logic [1:0]    m_sz = '0;
    logic [OW-1:0] m_off = '0;
    logic [31:0]   m_wd = '0, m_rd = '0;
    always @(posedge clk or negedge rst_an) begin
        bit         ok;
        logic [1:0] sz, ln;
        longint     a;
        if (!rst_an || !rst_sn) begin
            m_phase = 0; m_ack = 0; m_err = 0; m_req = 0;
        end else begin
            m_ack = 0; m_err = 0; m_req = 0;
            if (m_phase == 0) begin
                a = longint'(adr);
                if (cyc && stb && a >= longint'(BASE) && a < longint'(BASE) + SIZE) begin
                    spec(we, sel, ok, sz, ln);
                    if (ok) begin
                        m_req = 1; m_wr = we; m_last_wr = we; m_sz = sz;
                        m_off = OW'((a - longint'(BASE)) & ~longint'(3)) | OW'(ln);
                        m_wd  = wdat >> (8 * ln);
                        m_phase = 1;
                    end else begin
                        m_err = 1; m_phase = 2;
                    end
                end
            end else if (m_phase == 1) begin
                if (sq_done) begin m_ack = 1; m_rd = sq_rdata; m_phase = 2; end
            end else begin
                m_phase = 0;
            end
        end
    end

    // Compare on every falling edge.
    always @(negedge clk) begin
        chk(ack === m_ack, "R8 ack pulse", 64'(ack), 64'(m_ack));
        chk(err === m_err, "R6 err pulse", 64'(err), 64'(m_err));
        chk(rq_v === m_req, "R9 request pulse", 64'(rq_v), 64'(m_req));
        if (m_req && rq_v) begin
            chk(rq_w === m_wr, "R5 write flag", 64'(rq_w), 64'(m_wr));
            chk(rq_sz === m_sz, "R5 size code", 64'(rq_sz), 64'(m_sz));
            chk(rq_off === m_off, "R5 offset", 64'(rq_off), 64'(m_off));
            if (m_wr) chk(rq_wd === m_wd, "R11 lane data", 64'(rq_wd), 64'(m_wd));
        end
        if (m_ack && ack && !m_last_wr)
            chk(rdat === m_rd, "R4 read data", 64'(rdat), 64'(m_rd));
    end

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_tests++; n_fail++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    task automatic classic(input bit w, input logic [31:0] a, input logic [3:0] s,
                           input logic [31:0] d, input bit exp_err, input string tag);
        bit done = 0, ge = 0;
        @(negedge clk);
        cyc = 1; stb = 1; we = w; adr = a; sel = s; wdat = d;
        for (int k = 0; k < 100 && !done; k++) begin
            @(negedge clk);
            if (ack || err) begin done = 1; ge = err; end
        end
        cyc = 0; stb = 0;
        chk(done && ge == exp_err, tag, 64'({done, ge}), 64'({1'b1, exp_err}));
    endtask

    task automatic piped(input bit w, input logic [31:0] a, input logic [3:0] s,
                         input logic [31:0] d, input bit exp_err, input bit extra, input string tag);
        bit done = 0, ge = 0;
        @(negedge clk);
        cyc = 1; stb = 1; we = w; adr = a; sel = s; wdat = d;
        for (int k = 0; k < 100 && !done; k++) begin
            @(negedge clk);
            stb = 0;
            if (ack || err) begin done = 1; ge = err; end
            else if (extra && k == 2) begin
                stb = 1; we = 0; sel = 4'hF; adr = a + 32'd8;
            end
        end
        cyc = 0; stb = 0;
        chk(done && ge == exp_err, tag, 64'({done, ge}), 64'({1'b1, exp_err}));
    endtask

    task automatic quiet(input logic c, input logic s, input logic [31:0] a, input string tag);
        int terms = 0;
        @(negedge clk);
        cyc = c; stb = s; we = 0; sel = 4'hF; adr = a;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (ack || err || rq_v) terms++;
        end
        cyc = 0; stb = 0;
        chk(terms == 0, tag, 64'(terms), 64'd0);
    endtask

    initial begin
        // R1: outputs idle while held in asynchronous reset
        repeat (3) @(negedge clk);
        chk(!ack && !err && !rq_v, "R1 reset outputs", 64'({ack, err, rq_v}), 64'd0);
        rst_an = 1'b1;
        @(negedge clk);
        chk(!ack && !err && !rq_v, "R1 after release", 64'({ack, err, rq_v}), 64'd0);

        // R2 / R4: classic reads
        sq_lat = 2;
        classic(0, BASE + 32'h10, 4'hF, 32'h0, 0, "R2 classic read");
        classic(0, BASE + 32'hFFC, 4'hF, 32'h0, 0, "R4 last word read");

        // R5 / R11: every legal write mask
        classic(1, BASE + 32'h20, 4'hF, 32'hA1B2_C3D4, 0, "R5 word write");
        classic(1, BASE + 32'h24, 4'h3, 32'h1122_3344, 0, "R5 low half write");
        classic(1, BASE + 32'h28, 4'hC, 32'h5566_7788, 0, "R5 high half write");
        for (int b = 0; b < 4; b++)
            classic(1, BASE + 32'h30 + 32'(b), 4'(1 << b), 32'hDEAD_BEEF, 0, "R11 byte write");

        // R3: pipelined mode, varied latency
        sq_lat = 5;
        piped(0, BASE + 32'h40, 4'hF, 32'h0, 0, 0, "R3 piped read");
        piped(1, BASE + 32'h44, 4'h4, 32'h0BAD_F00D, 0, 0, "R3 piped byte write");
        sq_lat = 0;
        piped(1, BASE + 32'h48, 4'hC, 32'hCAFE_0001, 0, 0, "R3 piped half write");

        // R6: unsupported masks
        classic(0, BASE + 32'h50, 4'h3, 32'h0, 1, "R6 partial read");
        classic(1, BASE + 32'h54, 4'h6, 32'h0, 1, "R6 mask 0110");
        classic(1, BASE + 32'h58, 4'h0, 32'h0, 1, "R6 empty mask");
        piped(1, BASE + 32'h5C, 4'h7, 32'h0, 1, 0, "R6 piped mask 0111");

        // R7: ignored requests
        quiet(1, 1, BASE - 32'd4, "R7 below window");
        quiet(1, 1, BASE + 32'(SIZE), "R7 above window");
        quiet(0, 1, BASE + 32'h60, "R7 cycle low");
        quiet(1, 0, BASE + 32'h64, "R7 strobe low");

        // R9: strobe during in-flight transfer is ignored
        sq_lat = 6;
        piped(0, BASE + 32'h70, 4'hF, 32'h0, 0, 1, "R9 in-flight strobe");
        repeat (12) @(negedge clk);

        // R10: synchronous reset abandons a transfer
        begin
            int terms = 0;
            sq_lat = 8;
            @(negedge clk);
            cyc = 1; stb = 1; we = 0; sel = 4'hF; adr = BASE + 32'h80;
            @(negedge clk); stb = 0;
            @(negedge clk); rst_sn = 1'b0;
            @(negedge clk); rst_sn = 1'b1;
            chk(!ack && !err && !rq_v, "R1 sync reset outputs", 64'({ack, err, rq_v}), 64'd0);
            for (int k = 0; k < 16; k++) begin
                @(negedge clk);
                if (ack || err) terms++;
            end
            cyc = 0;
            chk(terms == 0, "R10 abandoned transfer", 64'(terms), 64'd0);
        end

        sq_lat = 1;
        classic(0, BASE + 32'h84, 4'hF, 32'h0, 0, "R10 works after sync reset");
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule